// File: doc/BRIEF.md
# Cascadable Serial-In Latched Output Driver

This block is a serial-to-parallel converter. Its twelve stages can drive print-head dots, relays or solenoids. It runs entirely in one system-clock domain. It takes four slow external control lines: a shift clock, serial data, a level-sensitive load strobe and an active-high blanking input. Each of these lines passes through a two-flop synchroniser. A rising edge of the synchronised shift clock advances the shift chain by one place.

While the load strobe is high, a holding register follows the chain. When the strobe drops, the holding register freezes. The holding register drives twelve active-low driver outputs, and blanking can force all of them off. The last chain stage is brought out as a serial output, so several devices can be chained.

After reset, the synchroniser flops hold the levels an undriven pin would settle to. The strobe and blanking lines reset high, and the shift clock and data lines reset low.

Top module: `ser_latch_driver`

## Requirements
- R1: Reset (rst_n low) clears the shift chain and the holding register to zero. After reset, drv_n_o reads all ones and ser_o reads 0.
- R2: Each rising edge of the synchronised shift clock shifts exactly once. Stage 1 takes ser_i, and each stage k passes its bit to stage k+1. A shift clock held high does not cause a further shift.
- R3: drv_n_o[i] reflects stage i+1. The first bit of twelve shifted bits therefore reaches drv_n_o[11] after the twelfth shift.
- R4: ser_o carries the last stage and changes on the same cycle as the shift. After twelve more shifts it has replayed the stored word, most recently entered bit last.
- R5: While the strobe is high, the holding register takes the chain value one system cycle later. This includes cycles in which a shift happens.
- R6: While the strobe is low, the holding register keeps its value while the chain shifts.
- R7: The outputs are inverted. A held 1 gives drv_n_o bit 0 (driver on), and a held 0 gives 1 (off).
- R8: With blank_i high, drv_n_o is all ones. Releasing blank_i restores the held data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_clk_i | input | 1 | External shift clock, asynchronous |
| ser_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Level load strobe, high = transparent |
| blank_i | input | 1 | High forces all outputs off |
| drv_n_o | output | STAGES | Active-low driver outputs, bit i = stage i+1 |
| ser_o | output | 1 | Last stage, for chaining |

## Verification
A shift and a transparent load can fall in the same system cycle. The bench provokes this by holding the strobe high through a whole twelve-bit shift sequence. After every shift, it compares the outputs with the inverse of a bench-side chain model. Any lag beyond one cycle, or a load of the pre-shift value, shows up as a mismatch on the freshly entered bit. Sweeps of walking-one patterns and mixed words check position mapping, hold, blanking and cascade replay.

// File: rtl/ser_latch_driver.sv
module ser_latch_driver #(
  parameter int STAGES = 12,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_clk_i,
  input  logic              ser_i,
  input  logic              strobe_i,
  input  logic              blank_i,
  output logic [STAGES-1:0] drv_n_o,
  output logic              ser_o
);

  logic [SYNC-1:0]   sclk_q, sdat_q, stb_q, blk_q;
  logic              sclk_d;
  logic [STAGES-1:0] chain, hold;
  logic              shift_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdat_q <= '0;
      stb_q  <= '1;
      blk_q  <= '1;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[SYNC-2:0], shift_clk_i};
      sdat_q <= {sdat_q[SYNC-2:0], ser_i};
      stb_q  <= {stb_q[SYNC-2:0], strobe_i};
      blk_q  <= {blk_q[SYNC-2:0], blank_i};
      sclk_d <= sclk_q[SYNC-1];
    end
  end

  assign shift_rise = sclk_q[SYNC-1] & ~sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      hold  <= '0;
    end else begin
      if (shift_rise) chain <= {chain[STAGES-2:0], sdat_q[SYNC-1]};
      if (stb_q[SYNC-1]) hold <= chain;
    end
  end

  assign drv_n_o = blk_q[SYNC-1] ? '1 : ~hold;
  assign ser_o   = chain[STAGES-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (chain == '0 && hold == '0));
  // R2
  no_spurious_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise |=> $stable(chain));
  // R4
  ser_out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> ser_o == $past(chain[STAGES-2]));
  // R5
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q[SYNC-1] |=> hold == $past(chain));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q[SYNC-1] |=> $stable(hold));
  // R8
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q[SYNC-1] |-> &drv_n_o);

endmodule

// File: tb/tb_ser_latch_driver.sv
module tb_ser_latch_driver;
  localparam int N = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, stb = 1'b0, blk = 1'b0;
  logic [N-1:0] drv_n;
  logic sout;
  logic [N-1:0] model;
  int total = 0, bad = 0;

  ser_latch_driver #(.STAGES(N), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .shift_clk_i(sclk), .ser_i(sdat),
    .strobe_i(stb), .blank_i(blk), .drv_n_o(drv_n), .ser_o(sout));

  always #10 clk = ~clk;

  task automatic wait_cy(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input int high_cy);
    sdat = b;
    wait_cy(3);
    sclk = 1'b1;
    wait_cy(high_cy);
    sclk = 1'b0;
    wait_cy(3);
    model = {model[N-2:0], b};
  endtask

  task automatic load_word(input logic [N-1:0] w);
    for (int i = N-1; i >= 0; i--) shift_bit(w[i], 6);
  endtask

  task automatic pulse_strobe;
    stb = 1'b1;
    wait_cy(6);
    stb = 1'b0;
    wait_cy(4);
  endtask

  initial begin
    #200000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] words [6];
    logic [N-1:0] held;
    model = '0;
    wait_cy(4);
    rst_n = 1'b1;
    wait_cy(4);
    chk("R1 outputs after reset", drv_n, '1);
    chk("R1 ser_o after reset", {{(N-1){1'b0}}, sout}, '0);

    for (int p = 0; p < N; p++) begin
      load_word(N'(1) << p);
      pulse_strobe();
      chk("R3 walking one position", drv_n, ~(N'(1) << p));
    end

    words[0] = 12'h000; words[1] = 12'hFFF; words[2] = 12'hA5C;
    words[3] = 12'h3E1; words[4] = 12'h801; words[5] = 12'h7B6;
    for (int k = 0; k < 6; k++) begin
      load_word(words[k]);
      pulse_strobe();
      chk("R7 inverted word", drv_n, ~words[k]);
      chk("R2 model agreement", drv_n, ~model);
    end

    held = words[5];
    load_word(12'h5A3);
    chk("R6 hold while shifting", drv_n, ~held);

    for (int i = N-1; i >= 0; i--) begin
      shift_bit(1'b0, 6);
      chk("R4 cascade replay", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, (i > 0) ? model[N-1] : model[N-1]});
    end
    chk("R4 chain drained", {{(N-1){1'b0}}, sout}, '0);
    chk("R6 still held", drv_n, ~held);

    load_word(12'hC35);
    for (int b = 0; b < 4; b++) begin
      shift_bit(1'b1, 30);
    end
    pulse_strobe();
    chk("R2 long high one shift each", drv_n, ~model);

    stb = 1'b1;
    wait_cy(6);
    for (int i = N-1; i >= 0; i--) begin
      shift_bit(12'h9D2 >> i, 6);
      chk("R5 transparent during shift", drv_n, ~model);
    end
    stb = 1'b0;
    wait_cy(4);

    held = model;
    blk = 1'b1;
    wait_cy(4);
    chk("R8 blank forces off", drv_n, '1);
    blk = 1'b0;
    wait_cy(4);
    chk("R8 release restores", drv_n, ~held);

    rst_n = 1'b0;
    wait_cy(3);
    rst_n = 1'b1;
    model = '0;
    wait_cy(4);
    chk("R1 reset mid operation", drv_n, '1);
    chk("R1 ser_o cleared", {{(N-1){1'b0}}, sout}, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule